// File: doc/BRIEF.md
# Per-Channel Fine Delay Phase Rotator

This block sits behind a channelizer and removes the fractional-sample part of a geometric delay together with the fringe phase. It multiplies each complex channel sample by a unit phasor. For channel `k` the phasor angle is `k·τ + φ` in units of one full turn. The fine delay `τ` is signed and produces a phase slope across the band. The phase offset `φ` is a constant added to every channel. The table that supplies cosine and sine is built on chip from a quarter wave.

Software programs a starting delay, a starting phase and a per-spectrum rate for each, along with the timestamp at which they take effect. After that the hardware interpolates both values on its own. It steps them once at every spectrum start until a new set is applied, so software only has to refresh the model occasionally. One instance serves one polarization. Each polarization therefore carries its own control registers.

Top module: `fdelay_rotator`

## Requirements
- R1: After reset the output is invalid and zero. The delay, phase and both rates are zero, so the samples of every spectrum before the first load pass with a zero angle.
- R2: For a valid beat with channel index `k`, the 32-bit phase word is `(k·τ + φ) mod 2^32`. Its top 12 bits select the angle `θ = 2π·addr/4096`.
- R3: The output is `re' = re·cosθ − im·sinθ` and `im' = re·sinθ + im·cosθ`, using 18-bit signed table values of amplitude 131071, with a result scaling of 2^−17.
- R4: A negative fine delay (two's complement `τ`) makes the angle decrease as the channel index grows.
- R5: At each valid spectrum-start beat with no load due, the delay increases by its rate and the phase increases by its rate, both modulo 2^32. The new values apply from that beat onward. Other beats do not step the values.
- R6: An armed set (delay, phase, both rates) takes effect at the first valid spectrum-start beat whose 48-bit timestamp is greater than or equal to the armed timestamp. In that spectrum it replaces the rate step.
- R7: Arming again before the load takes place overwrites the waiting set and its timestamp.
- R8: An arm that arrives in the same cycle as the spectrum start that applies the older waiting set leaves the older set applied. The new set then waits for its own timestamp.
- R9: Each result is rounded to nearest and saturated to the signed 16-bit range.
- R10: The latency is exactly 3 cycles. `out_valid`, `out_sos` and `out_chan` repeat the input values from 3 cycles earlier.
- R11: A beat with `in_valid` low, including one with `in_sos` high, produces no output and does not step or load the delay and phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat valid |
| in_sos | input | 1 | First beat of a spectrum |
| in_chan | input | 12 | Channel index of the beat |
| in_ts | input | 48 | Timestamp of the spectrum, in samples |
| in_re | input | 16 | Real part, signed |
| in_im | input | 16 | Imaginary part, signed |
| cfg_arm | input | 1 | Captures the set below as the waiting set |
| cfg_ts | input | 48 | Timestamp at which the waiting set applies |
| cfg_delay | input | 32 | Starting fine delay, turns per channel, signed |
| cfg_delay_rate | input | 32 | Delay step per spectrum |
| cfg_phase | input | 32 | Starting phase offset, turns |
| cfg_phase_rate | input | 32 | Phase step per spectrum |
| out_valid | output | 1 | Output beat valid |
| out_sos | output | 1 | Delayed spectrum-start marker |
| out_chan | output | 12 | Delayed channel index |
| out_re | output | 16 | Rotated real part |
| out_im | output | 16 | Rotated imaginary part |

## Verification
The timed load and the per-spectrum rate step both act on the spectrum-start beat, so one cycle must choose between them. The bench arms a set whose timestamp matches a spectrum that would otherwise step with nonzero rates. It then checks that the angles of that spectrum come from the loaded values and carry no added rate. A second collision puts a fresh arm on that same spectrum-start beat. The bench checks that the older set is applied there and that the fresh set appears only at its own, later timestamp.

// File: rtl/fdr_pkg.sv
package fdr_pkg;
    localparam int PH_W = 32;
    localparam int TS_W = 48;

    typedef logic [PH_W-1:0] phase_t;
    typedef logic [TS_W-1:0] stamp_t;

    typedef struct packed {
        phase_t delay;
        phase_t phase;
        phase_t d_rate;
        phase_t p_rate;
    } interp_t;
endpackage

// File: rtl/fdr_interp.sv
// Holds the running delay/phase and the armed set; steps or loads at spectrum start.
module fdr_interp
    import fdr_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    arm,
    input  stamp_t  arm_ts,
    input  interp_t arm_val,
    input  logic    step,
    input  stamp_t  step_ts,
    output phase_t  eff_delay,
    output phase_t  eff_phase,
    output phase_t  cur_delay,
    output phase_t  cur_phase,
    output logic    pend_valid
);
    typedef struct packed {
        interp_t cur;
        interp_t pend;
        stamp_t  pend_ts;
        logic    pend_v;
    } st_t;

    st_t  st_d, st_q;
    logic load;

    always_comb begin
        st_d = st_q;
        load = st_q.pend_v && step && (step_ts >= st_q.pend_ts);
        if (load) begin
            st_d.cur    = st_q.pend;
            st_d.pend_v = 1'b0;
        end else if (step) begin
            st_d.cur.delay = st_q.cur.delay + st_q.cur.d_rate;
            st_d.cur.phase = st_q.cur.phase + st_q.cur.p_rate;
        end
        if (arm) begin
            st_d.pend    = arm_val;
            st_d.pend_ts = arm_ts;
            st_d.pend_v  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // the values in force for the current beat (updated ones on a spectrum start)
    assign eff_delay  = st_d.cur.delay;
    assign eff_phase  = st_d.cur.phase;
    assign cur_delay  = st_q.cur.delay;
    assign cur_phase  = st_q.cur.phase;
    assign pend_valid = st_q.pend_v;
endmodule

// File: rtl/fdr_sincos.sv
// Quarter-wave table expanded to a full turn by mirroring and negation.
module fdr_sincos #(
    parameter int AW = 12,
    parameter int CW = 18
) (
    input  logic [AW-1:0]        addr,
    output logic signed [CW-1:0] cos_o,
    output logic signed [CW-1:0] sin_o
);
    localparam int QB  = AW - 2;
    localparam int QN  = 1 << QB;
    localparam int AMP = (1 << (CW - 1)) - 1;

    typedef logic signed [CW-1:0] tab_t [0:QN];

    function automatic tab_t build_tab();
        tab_t t;
        real  a;
        for (int i = 0; i <= QN; i++) begin
            a    = $sin(6.283185307179586 * real'(i) / real'(4 * QN)) * real'(AMP);
            t[i] = CW'($rtoi(a + 0.5));
        end
        return t;
    endfunction

    localparam tab_t QTAB = build_tab();

    function automatic logic signed [CW-1:0] pick(input logic [AW-1:0] a);
        logic [QB:0]           idx;
        logic signed [CW-1:0]  m;
        idx = a[AW-2] ? ((QB+1)'(QN) - {1'b0, a[QB-1:0]}) : {1'b0, a[QB-1:0]};
        m   = QTAB[idx];
        return a[AW-1] ? -m : m;
    endfunction

    assign sin_o = pick(addr);
    assign cos_o = pick(addr + AW'(QN));
endmodule

// File: rtl/fdr_cmul.sv
// Complex multiply by a unit phasor, round to nearest, saturate to DW bits.
module fdr_cmul #(
    parameter int DW = 16,
    parameter int CW = 18
) (
    input  logic signed [DW-1:0] x_re,
    input  logic signed [DW-1:0] x_im,
    input  logic signed [CW-1:0] c,
    input  logic signed [CW-1:0] s,
    output logic signed [DW-1:0] y_re,
    output logic signed [DW-1:0] y_im
);
    localparam int PW = DW + CW + 1;
    localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic signed [PW-1:0] MINV = ~MAXV;
    localparam logic signed [PW-1:0] HALF = PW'(1) << (CW - 2);

    logic signed [PW-1:0] acc_re, acc_im, sh_re, sh_im;

    function automatic logic signed [DW-1:0] sat(input logic signed [PW-1:0] v);
        if (v > MAXV)      return DW'(MAXV);
        else if (v < MINV) return DW'(MINV);
        else               return DW'(v);
    endfunction

    always_comb begin
        acc_re = PW'(x_re) * PW'(c) - PW'(x_im) * PW'(s);
        acc_im = PW'(x_re) * PW'(s) + PW'(x_im) * PW'(c);
        sh_re  = (acc_re + HALF) >>> (CW - 1);
        sh_im  = (acc_im + HALF) >>> (CW - 1);
        y_re   = sat(sh_re);
        y_im   = sat(sh_im);
    end
endmodule

// File: rtl/fdelay_rotator.sv
module fdelay_rotator
    import fdr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CHAN_W = 12,
    parameter int COEF_W = 18,
    parameter int TAB_AW = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic                     in_sos,
    input  logic [CHAN_W-1:0]        in_chan,
    input  logic [TS_W-1:0]          in_ts,
    input  logic signed [DATA_W-1:0] in_re,
    input  logic signed [DATA_W-1:0] in_im,
    input  logic                     cfg_arm,
    input  logic [TS_W-1:0]          cfg_ts,
    input  logic [PH_W-1:0]          cfg_delay,
    input  logic [PH_W-1:0]          cfg_delay_rate,
    input  logic [PH_W-1:0]          cfg_phase,
    input  logic [PH_W-1:0]          cfg_phase_rate,
    output logic                     out_valid,
    output logic                     out_sos,
    output logic [CHAN_W-1:0]        out_chan,
    output logic signed [DATA_W-1:0] out_re,
    output logic signed [DATA_W-1:0] out_im
);
    localparam int SHIFT = PH_W - TAB_AW;

    typedef struct packed {
        logic                     valid;
        logic                     sos;
        logic [CHAN_W-1:0]        chan;
        logic signed [DATA_W-1:0] re;
        logic signed [DATA_W-1:0] im;
    } beat_t;

    typedef struct packed {
        beat_t                    a_beat;
        logic [TAB_AW-1:0]        a_addr;
        beat_t                    b_beat;
        logic signed [COEF_W-1:0] b_cos;
        logic signed [COEF_W-1:0] b_sin;
        beat_t                    c_beat;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    phase_t  eff_delay, eff_phase, cur_delay, cur_phase;
    logic    pend_valid;
    interp_t arm_val;
    phase_t  idx;
    logic signed [COEF_W-1:0] tab_cos, tab_sin;
    logic signed [DATA_W-1:0] rot_re, rot_im;

    assign arm_val = '{delay: cfg_delay, phase: cfg_phase,
                       d_rate: cfg_delay_rate, p_rate: cfg_phase_rate};

    fdr_interp u_interp (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (cfg_arm),
        .arm_ts     (cfg_ts),
        .arm_val    (arm_val),
        .step       (in_valid && in_sos),
        .step_ts    (in_ts),
        .eff_delay  (eff_delay),
        .eff_phase  (eff_phase),
        .cur_delay  (cur_delay),
        .cur_phase  (cur_phase),
        .pend_valid (pend_valid)
    );

    fdr_sincos #(.AW(TAB_AW), .CW(COEF_W)) u_sincos (
        .addr  (pipe_q.a_addr),
        .cos_o (tab_cos),
        .sin_o (tab_sin)
    );

    fdr_cmul #(.DW(DATA_W), .CW(COEF_W)) u_cmul (
        .x_re (pipe_q.b_beat.re),
        .x_im (pipe_q.b_beat.im),
        .c    (pipe_q.b_cos),
        .s    (pipe_q.b_sin),
        .y_re (rot_re),
        .y_im (rot_im)
    );

    always_comb begin
        pipe_d = pipe_q;
        // stage a: phase word for this channel
        idx                 = PH_W'(in_chan) * eff_delay + eff_phase;
        pipe_d.a_beat.valid = in_valid;
        pipe_d.a_beat.sos   = in_valid && in_sos;
        pipe_d.a_beat.chan  = in_chan;
        pipe_d.a_beat.re    = in_re;
        pipe_d.a_beat.im    = in_im;
        pipe_d.a_addr       = TAB_AW'(idx >> SHIFT);
        // stage b: table lookup
        pipe_d.b_beat       = pipe_q.a_beat;
        pipe_d.b_cos        = tab_cos;
        pipe_d.b_sin        = tab_sin;
        // stage c: rotated sample
        pipe_d.c_beat       = pipe_q.b_beat;
        pipe_d.c_beat.re    = rot_re;
        pipe_d.c_beat.im    = rot_im;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid = pipe_q.c_beat.valid;
    assign out_sos   = pipe_q.c_beat.sos;
    assign out_chan  = pipe_q.c_beat.chan;
    assign out_re    = pipe_q.c_beat.re;
    assign out_im    = pipe_q.c_beat.im;
endmodule

// File: rtl/fdr_chk.sv
module fdr_chk #(
    parameter int CHAN_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_sos,
    input logic [CHAN_W-1:0] in_chan,
    input logic              cfg_arm,
    input logic              out_valid,
    input logic              out_sos,
    input logic [CHAN_W-1:0] out_chan,
    input logic [31:0]       cur_delay,
    input logic [31:0]       cur_phase,
    input logic              pend_valid
);
    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    p_latency_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    p_latency_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid) |->
            (out_sos == $past(in_sos, 3) && out_chan == $past(in_chan, 3)));

    p_hold_between_starts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sos) |=> ($stable(cur_delay) && $stable(cur_phase)));

    p_idle_no_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(cur_phase));

    p_arm_pending_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_arm |=> pend_valid);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> !out_valid);
endmodule

bind fdelay_rotator fdr_chk #(.CHAN_W(CHAN_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_sos     (in_sos),
    .in_chan    (in_chan),
    .cfg_arm    (cfg_arm),
    .out_valid  (out_valid),
    .out_sos    (out_sos),
    .out_chan   (out_chan),
    .cur_delay  (cur_delay),
    .cur_phase  (cur_phase),
    .pend_valid (pend_valid)
);

// File: tb/fdelay_rotator_tb_top.sv
module fdelay_rotator_tb_top;
    localparam real TWO_PI = 6.283185307179586;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               in_valid = 0, in_sos = 0;
    logic [11:0]        in_chan = '0;
    logic [47:0]        in_ts = '0;
    logic signed [15:0] in_re = '0, in_im = '0;
    logic               cfg_arm = 0;
    logic [47:0]        cfg_ts = '0;
    logic [31:0]        cfg_delay = '0, cfg_delay_rate = '0, cfg_phase = '0, cfg_phase_rate = '0;
    logic               out_valid, out_sos;
    logic [11:0]        out_chan;
    logic signed [15:0] out_re, out_im;

    always #5 clk = ~clk;

    fdelay_rotator dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sos(in_sos),
        .in_chan(in_chan), .in_ts(in_ts), .in_re(in_re), .in_im(in_im),
        .cfg_arm(cfg_arm), .cfg_ts(cfg_ts), .cfg_delay(cfg_delay),
        .cfg_delay_rate(cfg_delay_rate), .cfg_phase(cfg_phase),
        .cfg_phase_rate(cfg_phase_rate), .out_valid(out_valid),
        .out_sos(out_sos), .out_chan(out_chan), .out_re(out_re), .out_im(out_im)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 0;

    // expected-output ring, slot = cycle modulo 8
    bit    ev [8];
    bit    es [8];
    int    ech[8];
    real   ere[8];
    real   eim[8];
    string etag[8];

    // behavioural model state
    logic [31:0] m_d = 0, m_p = 0, m_dr = 0, m_pr = 0;
    bit          p_v = 0;
    logic [47:0] p_ts = 0;
    logic [31:0] p_d = 0, p_p = 0, p_dr = 0, p_pr = 0;

    // arm request for the next beat
    bit          a_req = 0;
    logic [47:0] a_ts;
    logic [31:0] a_d, a_p, a_dr, a_pr;
    string       tag = "R1";

    task automatic fail(string req, string what, real act, real exp);
        errors++;
        $display("FAIL %s %s actual=%0f expected=%0f", req, what, act, exp);
    endtask

    task automatic arm(logic [47:0] ts, logic [31:0] d, logic [31:0] dr,
                       logic [31:0] p, logic [31:0] pr);
        a_req = 1; a_ts = ts; a_d = d; a_dr = dr; a_p = p; a_pr = pr;
    endtask

    function automatic real clampr(real v);
        if (v > 32767.0)  return 32767.0;
        if (v < -32768.0) return -32768.0;
        return v;
    endfunction

    task automatic beat(bit v, bit s, int ch, logic [47:0] ts, int re, int im);
        int          sl, ws;
        logic [31:0] ph;
        real         th, r, i;
        @(negedge clk);
        sl = cyc % 8;
        checks++;
        if (out_valid !== ev[sl]) fail("R10", "out_valid", real'(out_valid), real'(ev[sl]));
        else if (ev[sl]) begin
            if (out_sos !== es[sl] || int'(out_chan) != ech[sl])
                fail("R10", "sos/chan", real'(out_chan), real'(ech[sl]));
            if ((real'(out_re) - ere[sl]) > 2.0 || (ere[sl] - real'(out_re)) > 2.0)
                fail(etag[sl], "out_re", real'(out_re), ere[sl]);
            if ((real'(out_im) - eim[sl]) > 2.0 || (eim[sl] - real'(out_im)) > 2.0)
                fail(etag[sl], "out_im", real'(out_im), eim[sl]);
        end
        in_valid = v; in_sos = s; in_chan = 12'(ch); in_ts = ts;
        in_re = 16'(re); in_im = 16'(im);
        cfg_arm = a_req; cfg_ts = a_ts; cfg_delay = a_d; cfg_delay_rate = a_dr;
        cfg_phase = a_p; cfg_phase_rate = a_pr;
        // model
        if (v && s) begin
            if (p_v && ts >= p_ts) begin
                m_d = p_d; m_p = p_p; m_dr = p_dr; m_pr = p_pr; p_v = 0;
            end else begin
                m_d = m_d + m_dr; m_p = m_p + m_pr;
            end
        end
        ws = (cyc + 3) % 8;
        ev[ws] = v; es[ws] = v && s; ech[ws] = ch & 12'hFFF; etag[ws] = tag;
        if (v) begin
            ph = 32'(ch) * m_d + m_p;
            th = TWO_PI * real'(ph >> 20) / 4096.0;
            r  = real'(16'sh0 + 16'(re)) * 0.0;
            r  = real'($signed(16'(re))) * $cos(th) - real'($signed(16'(im))) * $sin(th);
            i  = real'($signed(16'(re))) * $sin(th) + real'($signed(16'(im))) * $cos(th);
            ere[ws] = clampr(r); eim[ws] = clampr(i);
        end
        if (a_req) begin
            p_v = 1; p_ts = a_ts; p_d = a_d; p_dr = a_dr; p_p = a_p; p_pr = a_pr;
            a_req = 0;
        end
        cyc++;
    endtask

    task automatic spectrum(logic [47:0] ts, int n, int base, int stride);
        for (int k = 0; k < n; k++)
            beat(1, k == 0, base + k * stride, ts, int'($urandom_range(60000)) - 30000,
                 int'($urandom_range(60000)) - 30000);
    endtask

    initial begin
        for (int k = 0; k < 8; k++) ev[k] = 0;
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1: reset state visible at the ports
        checks++;
        if (out_valid !== 1'b0 || out_re !== 16'sd0)
            fail("R1", "reset out", real'(out_re), 0.0);
        tag = "R1";
        spectrum(48'd10, 6, 0, 700);
        // R2/R3: load a slope and an offset at ts 100; ts 50 must stay untouched (R6)
        arm(48'd100, 32'h0010_0000, 32'd0, 32'h4000_0000, 32'd0);
        tag = "R6"; spectrum(48'd50, 6, 3, 411);
        tag = "R2"; spectrum(48'd100, 8, 0, 1);
        tag = "R3"; spectrum(48'd120, 8, 100, 333);
        // R4: negative slope
        arm(48'd130, 32'hFFD0_0000, 32'd0, 32'h0000_0000, 32'd0);
        tag = "R4"; spectrum(48'd130, 8, 0, 5);
        // R5 with R11: rates, idle beats and a stray marker without valid
        arm(48'd200, 32'h0014_0000, 32'h0008_0000, 32'h1000_0000, 32'h0300_0000);
        tag = "R5";
        for (int s = 0; s < 5; s++) begin
            beat(1, 1, 7, 48'd200 + 48'(s * 10), 20000, -5000);
            beat(0, 1, 9, 48'd999, 1, 1);
            tag = "R11";
            beat(1, 0, 900, 48'd0, -12000, 17000);
            beat(0, 0, 0, 48'd0, 0, 0);
            tag = "R5";
            beat(1, 0, 2047, 48'd0, 9000, 9000);
        end
        // R7: second arm replaces the first before either applies
        arm(48'd500, 32'h0100_0000, 32'd0, 32'd0, 32'd0);
        beat(0, 0, 0, 48'd0, 0, 0);
        arm(48'd520, 32'h0003_0000, 32'd0, 32'h8000_0000, 32'd0);
        tag = "R7"; spectrum(48'd500, 6, 1, 77);
        spectrum(48'd520, 6, 1, 77);
        // R6/R8: load coincides with a rate step and with a fresh arm
        arm(48'd600, 32'h0020_0000, 32'h0001_0000, 32'h0800_0000, 32'h0400_0000);
        spectrum(48'd590, 4, 0, 9);
        tag = "R8";
        arm(48'd700, 32'hFF00_0000, 32'd0, 32'h2000_0000, 32'd0);
        spectrum(48'd600, 6, 0, 9);
        spectrum(48'd650, 6, 0, 9);
        spectrum(48'd700, 6, 0, 9);
        // R6: late spectrum still takes a past-due set
        arm(48'd800, 32'h0000_0000, 32'd0, 32'h2000_0000, 32'd0);
        tag = "R6"; spectrum(48'd790, 3, 0, 1);
        spectrum(48'd810, 3, 0, 1);
        // R9: saturation at 45 degrees and full-scale input at zero angle
        tag = "R9";
        beat(1, 1, 0, 48'd900, -32768, -32768);
        beat(1, 0, 5, 48'd900, 32767, 32767);
        beat(1, 0, 2, 48'd900, -32768, 32767);
        arm(48'd910, 32'd0, 32'd0, 32'd0, 32'd0);
        beat(0, 0, 0, 48'd0, 0, 0);
        beat(1, 1, 0, 48'd910, -32768, 32767);
        beat(1, 0, 1, 48'd910, 32767, -32768);
        // mixed traffic with random arms
        tag = "R2";
        for (int s = 0; s < 40; s++) begin
            if ($urandom_range(2) == 0)
                arm(48'd1000 + 48'(s * 10 + $urandom_range(25)), $urandom(), $urandom(),
                    $urandom(), $urandom());
            for (int k = 0; k < 12; k++) begin
                if ($urandom_range(3) == 0) beat(0, $urandom_range(1) == 1, 0, 48'd0, 0, 0);
                beat(1, k == 0, int'($urandom_range(4095)), 48'd1000 + 48'(s * 10),
                     int'($urandom_range(65535)) - 32768, int'($urandom_range(65535)) - 32768);
            end
        end
        repeat (4) beat(0, 0, 0, 48'd0, 0, 0);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL R10 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule